// File: doc/BRIEF.md
# Variable-Width Operand Specifier Parser

This block takes one operation word and splits it into a fixed header and a run of operand specifiers. The header carries a condition mode, a condition stack index and an opcode. The specifiers that follow it have variable length and are packed back to back. Each one starts with a prefix code that fixes its length, so the position of every specifier depends on the lengths of all the specifiers before it.

The parser walks the body of the word from its most significant bit downward. It decodes each specifier into a kind code, a bit length, up to two stack indices and a value. Immediates and offsets in that value are sign-extended as two's complement numbers. Parsing stops, without raising an error, as soon as the remaining bits cannot hold the specifier whose prefix they begin with. The records come out in a fixed-size array with one valid flag per record, together with the number of records found.

The decode is purely combinational. A parameter places an optional register stage on all outputs. Later stages decide which records are destinations and which are sources, using a per-opcode count. Executing the operation is out of scope here.

Top module: `opspec_parser`

## Requirements
- R1: The header fields are taken from the word's top 14 bits. `cond_mode` comes from bits 47:46, `cond_stack` from bits 45:43 and `opcode` from bits 42:34.
- R2: Each specifier's kind code and length follow from its prefix:
  - prefix 000 gives kind 0 (stack pop/push), 6 bits;
  - prefix 001 gives kind 1 (stack peek), 6 bits;
  - prefix 010 gives kind 2 (8-bit immediate), 11 bits;
  - prefix 011 gives kind 3 (16-bit immediate), 19 bits;
  - prefix 100 gives kind 4 (31-bit immediate), 34 bits;
  - prefix 101 gives kind 5 (offset from the condition stack's base register), 19 bits;
  - prefix 110 gives kind 6 (offset from the condition stack's top value), 19 bits;
  - prefix 1110 gives kind 7 (base register select), 7 bits;
  - prefix 1111 gives kind 8 (base register plus top value address), 10 bits.
- R3: Stack indices are the 3 bits right after the prefix.
  - Kinds 0, 1 and 7 put that index in `idx_a`.
  - Kind 8 puts the base-register stack in `idx_a` and the top-value stack (the next 3 bits) in `idx_b`.
- R4: Immediate kinds 2, 3 and 4 report their 8, 16 or 31 payload bits sign-extended to 32 bits in `value`.
- R5: Offset kinds 5 and 6 report their 16 payload bits sign-extended to 32 bits in `value`.
- R6: The first specifier starts at bit 33. Each following specifier starts directly below the previous one, with no gap.
- R7: Parsing stops when the next specifier's length exceeds the bits that remain; bits below bit 0 read as 0 when the prefix is decoded.
  - At most 5 records are produced.
  - `spec_valid` is set for records 0 to count-1 only.
  - `spec_count` equals the number of set valid flags.
- R8: A record whose valid flag is clear has kind, length, both indices and value all zero.
- R9: Any index or value field that a valid record's kind does not use reads zero. This means value is zero for kinds 0, 1, 7 and 8, and `idx_b` is zero for every kind except 8.
- R10: With `REG_OUT`=1 (the default), every output shows the decode of the word present one clock earlier, and all outputs are zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| op_word | input | 48 | Operation word to parse |
| cond_mode | output | 2 | Header condition mode |
| cond_stack | output | 3 | Header condition stack index |
| opcode | output | 9 | Header opcode |
| spec_count | output | 3 | Number of specifiers decoded |
| spec_valid | output | 5 | Valid flag per record, record 0 in bit 0 |
| spec_kind | output | 20 | Kind codes, record i in bits 4i+3:4i |
| spec_len | output | 30 | Bit lengths, record i in bits 6i+5:6i |
| spec_idx_a | output | 15 | First stack index, record i in bits 3i+2:3i |
| spec_idx_b | output | 15 | Second stack index, record i in bits 3i+2:3i |
| spec_value | output | 160 | Sign-extended value, record i in bits 32i+31:32i |

## Verification
The hardest case to reach from the ports is an early stop. Here the few leftover bits begin a prefix whose specifier is longer than the bits that remain. One example is a 1111 prefix with only five bits left; another is a 110 prefix with fifteen bits left. Random words rarely end on such a boundary. Directed words therefore pack specifier chains to exact totals of 29, 30 and 34 bits, so that both the stop rule and an exact fit are exercised. Several hundred random words then cover the mixing of prefixes, against a bit-walking reference model in the bench.

// File: rtl/opspec_pkg.sv
package opspec_pkg;
   localparam int KIND_W   = 4;
   localparam int LEN_W    = 6;
   localparam int IDX_W    = 3;
   localparam int VAL_W    = 32;
   localparam int HDR_W    = 14;
   localparam int MIN_LEN  = 6;
   localparam int MAX_LEN  = 34;

   typedef enum logic [KIND_W-1:0] {
      K_STK_RW    = 4'd0,
      K_STK_PEEK  = 4'd1,
      K_IMM8      = 4'd2,
      K_IMM16     = 4'd3,
      K_IMM31     = 4'd4,
      K_OFS_BASE  = 4'd5,
      K_OFS_TOP   = 4'd6,
      K_BASE_REG  = 4'd7,
      K_ADDR_PAIR = 4'd8
   } spec_kind_e;

   typedef struct packed {
      logic                    valid;
      spec_kind_e              kind;
      logic [LEN_W-1:0]        len;
      logic [IDX_W-1:0]        idx_a;
      logic [IDX_W-1:0]        idx_b;
      logic [VAL_W-1:0]        value;
   } spec_rec_t;
endpackage

// File: rtl/opspec_slot.sv
module opspec_slot
   import opspec_pkg::*;
#(
   parameter int BODY_W = 34
) (
   input  logic              enable,
   input  logic [BODY_W-1:0] body,
   input  logic [LEN_W-1:0]  used,
   output spec_rec_t         rec,
   output logic [LEN_W-1:0]  used_next,
   output logic              ok
);
   localparam logic [LEN_W-1:0] BODY_L = LEN_W'(BODY_W);

   logic [BODY_W-1:0]  win;
   logic [MAX_LEN-1:0] w;
   logic [LEN_W-1:0]   avail;
   logic [LEN_W-1:0]   need;
   spec_rec_t          cand;

   // align the current specifier at the top of the window
   assign win   = body << used;
   assign w     = win[BODY_W-1 -: MAX_LEN];
   assign avail = BODY_L - used;

   always_comb begin
      cand       = '0;
      cand.valid = 1'b1;
      need       = LEN_W'(MIN_LEN);
      unique case (w[33:31])
         3'b000: begin
            cand.kind  = K_STK_RW;
            need       = 6'd6;
            cand.idx_a = w[30:28];
         end
         3'b001: begin
            cand.kind  = K_STK_PEEK;
            need       = 6'd6;
            cand.idx_a = w[30:28];
         end
         3'b010: begin
            cand.kind  = K_IMM8;
            need       = 6'd11;
            cand.value = {{(VAL_W-8){w[30]}}, w[30:23]};
         end
         3'b011: begin
            cand.kind  = K_IMM16;
            need       = 6'd19;
            cand.value = {{(VAL_W-16){w[30]}}, w[30:15]};
         end
         3'b100: begin
            cand.kind  = K_IMM31;
            need       = 6'd34;
            cand.value = {{(VAL_W-31){w[30]}}, w[30:0]};
         end
         3'b101: begin
            cand.kind  = K_OFS_BASE;
            need       = 6'd19;
            cand.value = {{(VAL_W-16){w[30]}}, w[30:15]};
         end
         3'b110: begin
            cand.kind  = K_OFS_TOP;
            need       = 6'd19;
            cand.value = {{(VAL_W-16){w[30]}}, w[30:15]};
         end
         default: begin
            if (w[30]) begin
               cand.kind  = K_ADDR_PAIR;
               need       = 6'd10;
               cand.idx_a = w[29:27];
               cand.idx_b = w[26:24];
            end else begin
               cand.kind  = K_BASE_REG;
               need       = 6'd7;
               cand.idx_a = w[29:27];
            end
         end
      endcase
      cand.len = need;
   end

   assign ok        = enable && (need <= avail);
   assign rec       = ok ? cand : '0;
   assign used_next = ok ? used + need : used;
endmodule

// File: rtl/opspec_out_stage.sv
module opspec_out_stage #(
   parameter int W       = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/opspec_parser.sv
module opspec_parser
   import opspec_pkg::*;
#(
   parameter int  WORD_W   = 48,
   parameter bit  REG_OUT  = 1'b1,
   localparam int BODY_W   = WORD_W - HDR_W,
   localparam int MAX_SPEC = BODY_W / MIN_LEN,
   localparam int CNT_W    = $clog2(MAX_SPEC + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [WORD_W-1:0]         op_word,
   output logic [1:0]                cond_mode,
   output logic [2:0]                cond_stack,
   output logic [8:0]                opcode,
   output logic [CNT_W-1:0]          spec_count,
   output logic [MAX_SPEC-1:0]       spec_valid,
   output logic [MAX_SPEC*KIND_W-1:0] spec_kind,
   output logic [MAX_SPEC*LEN_W-1:0] spec_len,
   output logic [MAX_SPEC*IDX_W-1:0] spec_idx_a,
   output logic [MAX_SPEC*IDX_W-1:0] spec_idx_b,
   output logic [MAX_SPEC*VAL_W-1:0] spec_value
);
   localparam int TOT_W = HDR_W + CNT_W
                        + MAX_SPEC * (1 + KIND_W + LEN_W + 2 * IDX_W + VAL_W);

   generate
      if (BODY_W < MAX_LEN || BODY_W > 63) begin : g_bad_width
         $error("opspec_parser: body width must lie between 34 and 63 bits");
      end
   endgenerate

   logic [BODY_W-1:0]         body;
   logic [LEN_W-1:0]          used_c [MAX_SPEC+1];
   logic                      ok_c   [MAX_SPEC+1];
   spec_rec_t                 rec_c  [MAX_SPEC];

   logic [CNT_W-1:0]          c_count;
   logic [MAX_SPEC-1:0]       c_valid;
   logic [MAX_SPEC*KIND_W-1:0] c_kind;
   logic [MAX_SPEC*LEN_W-1:0] c_len;
   logic [MAX_SPEC*IDX_W-1:0] c_ia;
   logic [MAX_SPEC*IDX_W-1:0] c_ib;
   logic [MAX_SPEC*VAL_W-1:0] c_val;
   logic [TOT_W-1:0]          pre;
   logic [TOT_W-1:0]          post;

   assign body      = op_word[BODY_W-1:0];
   assign used_c[0] = '0;
   assign ok_c[0]   = 1'b1;

   // chained slots: each one starts where the previous one ended
   generate
      for (genvar i = 0; i < MAX_SPEC; i++) begin : g_slot
         opspec_slot #(.BODY_W(BODY_W)) u_slot (
            .enable   (ok_c[i]),
            .body     (body),
            .used     (used_c[i]),
            .rec      (rec_c[i]),
            .used_next(used_c[i+1]),
            .ok       (ok_c[i+1])
         );
         assign c_valid[i]                 = rec_c[i].valid;
         assign c_kind[i*KIND_W +: KIND_W] = rec_c[i].kind;
         assign c_len[i*LEN_W +: LEN_W]    = rec_c[i].len;
         assign c_ia[i*IDX_W +: IDX_W]     = rec_c[i].idx_a;
         assign c_ib[i*IDX_W +: IDX_W]     = rec_c[i].idx_b;
         assign c_val[i*VAL_W +: VAL_W]    = rec_c[i].value;
      end
   endgenerate

   always_comb begin
      c_count = '0;
      for (int i = 0; i < MAX_SPEC; i++) c_count = c_count + CNT_W'(c_valid[i]);
   end

   assign pre = {op_word[WORD_W-1 -: HDR_W], c_count, c_valid,
                 c_kind, c_len, c_ia, c_ib, c_val};

   opspec_out_stage #(.W(TOT_W), .REG_OUT(REG_OUT)) u_out (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pre),
      .q    (post)
   );

   assign {cond_mode, cond_stack, opcode, spec_count, spec_valid,
           spec_kind, spec_len, spec_idx_a, spec_idx_b, spec_value} = post;

   // ---------------- assertions ----------------
   logic [LEN_W+2:0] len_sum;
   always_comb begin
      len_sum = '0;
      for (int i = 0; i < MAX_SPEC; i++)
         len_sum = len_sum + (LEN_W+3)'(spec_len[i*LEN_W +: LEN_W]);
   end

   a_r7_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
      ((spec_valid + 1'b1) & spec_valid) == '0);

   a_r7_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
      32'(spec_count) == $countones(spec_valid));

   a_r6_fits_body: assert property (@(posedge clk) disable iff (!rst_n)
      len_sum <= (LEN_W+3)'(BODY_W) && used_c[MAX_SPEC] <= LEN_W'(BODY_W));

   generate
      for (genvar i = 0; i < MAX_SPEC; i++) begin : g_chk
         a_r8_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !spec_valid[i] |-> (spec_kind[i*KIND_W +: KIND_W] == '0 &&
                                spec_len[i*LEN_W +: LEN_W] == '0 &&
                                spec_value[i*VAL_W +: VAL_W] == '0));
      end
      if (REG_OUT) begin : g_lat_chk
         a_r10_header_latency: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> {cond_mode, cond_stack, opcode} ==
                     $past(op_word[WORD_W-1 -: HDR_W]));
      end
   endgenerate
endmodule

// File: tb/opspec_parser_test.sv
module opspec_parser_test;
   logic         clk = 1'b0;
   logic         rst_n;
   logic [47:0]  op_word;
   logic [1:0]   cond_mode;
   logic [2:0]   cond_stack;
   logic [8:0]   opcode;
   logic [2:0]   spec_count;
   logic [4:0]   spec_valid;
   logic [19:0]  spec_kind;
   logic [29:0]  spec_len;
   logic [14:0]  spec_idx_a;
   logic [14:0]  spec_idx_b;
   logic [159:0] spec_value;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #2 clk = ~clk;

   opspec_parser uut (
      .clk(clk), .rst_n(rst_n), .op_word(op_word),
      .cond_mode(cond_mode), .cond_stack(cond_stack), .opcode(opcode),
      .spec_count(spec_count), .spec_valid(spec_valid), .spec_kind(spec_kind),
      .spec_len(spec_len), .spec_idx_a(spec_idx_a), .spec_idx_b(spec_idx_b),
      .spec_value(spec_value)
   );

   // expected results from the behavioural model
   int          e_cnt;
   int          e_kind [5];
   int          e_len  [5];
   int          e_ia   [5];
   int          e_ib   [5];
   longint      e_val  [5];

   task automatic check(input bit good, input string tag, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic longint bits_at(input logic [47:0] w, input int hi, input int n);
      longint v = 0;
      for (int k = 0; k < n; k++) begin
         int p = hi - k;
         v = (v << 1) | ((p >= 0) ? longint'(w[p]) : 0);
      end
      return v;
   endfunction

   function automatic longint sext(input longint v, input int n);
      if (v >= (longint'(1) << (n - 1))) return v - (longint'(1) << n);
      return v;
   endfunction

   task automatic model(input logic [47:0] w);
      int pos = 33;
      e_cnt = 0;
      for (int i = 0; i < 5; i++) begin
         e_kind[i] = 0; e_len[i] = 0; e_ia[i] = 0; e_ib[i] = 0; e_val[i] = 0;
      end
      while (e_cnt < 5) begin
         int rem = pos + 1;
         int pf  = int'(bits_at(w, pos, 3));
         int k, len;
         case (pf)
            0: begin k = 0; len = 6;  end
            1: begin k = 1; len = 6;  end
            2: begin k = 2; len = 11; end
            3: begin k = 3; len = 19; end
            4: begin k = 4; len = 34; end
            5: begin k = 5; len = 19; end
            6: begin k = 6; len = 19; end
            default: begin
               if (bits_at(w, pos - 3, 1) == 1) begin k = 8; len = 10; end
               else begin k = 7; len = 7; end
            end
         endcase
         if (len > rem) break;
         e_kind[e_cnt] = k;
         e_len[e_cnt]  = len;
         case (k)
            0, 1: e_ia[e_cnt] = int'(bits_at(w, pos - 3, 3));
            2: e_val[e_cnt] = sext(bits_at(w, pos - 3, 8), 8);
            3, 5, 6: e_val[e_cnt] = sext(bits_at(w, pos - 3, 16), 16);
            4: e_val[e_cnt] = sext(bits_at(w, pos - 3, 31), 31);
            7: e_ia[e_cnt] = int'(bits_at(w, pos - 4, 3));
            default: begin
               e_ia[e_cnt] = int'(bits_at(w, pos - 4, 3));
               e_ib[e_cnt] = int'(bits_at(w, pos - 7, 3));
            end
         endcase
         pos = pos - len;
         e_cnt++;
      end
   endtask

   task automatic compare(input logic [47:0] w);
      model(w);
      check({cond_mode, cond_stack, opcode} == w[47:34], "R1 R10", "header",
            longint'({cond_mode, cond_stack, opcode}), longint'(w[47:34]));
      check(int'(spec_count) == e_cnt, "R7", "count", spec_count, e_cnt);
      check(spec_valid == 5'((1 << e_cnt) - 1), "R7", "valid flags",
            spec_valid, (1 << e_cnt) - 1);
      for (int i = 0; i < 5; i++) begin
         int     ak = int'(spec_kind[i*4 +: 4]);
         int     al = int'(spec_len[i*6 +: 6]);
         int     aa = int'(spec_idx_a[i*3 +: 3]);
         int     ab = int'(spec_idx_b[i*3 +: 3]);
         longint av = longint'(signed'(spec_value[i*32 +: 32]));
         if (i < e_cnt) begin
            check(ak == e_kind[i], "R2 R6", "kind", ak, e_kind[i]);
            check(al == e_len[i],  "R2 R6", "length", al, e_len[i]);
            check(aa == e_ia[i],   "R3", "idx_a", aa, e_ia[i]);
            check(ab == e_ib[i],   (e_kind[i] == 8) ? "R3" : "R9", "idx_b", ab, e_ib[i]);
            if (e_kind[i] inside {2, 3, 4})
               check(av == e_val[i], "R4", "immediate", av, e_val[i]);
            else if (e_kind[i] inside {5, 6})
               check(av == e_val[i], "R5", "offset", av, e_val[i]);
            else
               check(av == e_val[i], "R9", "unused value", av, e_val[i]);
         end else begin
            check(ak == 0 && al == 0 && aa == 0 && ab == 0 && av == 0,
                  "R8", "empty record", longint'(ak + al + aa + ab) + av, 0);
         end
      end
   endtask

   logic [47:0] dir [9];
   localparam logic [13:0] H1 = {2'b01, 3'd5, 9'h1A3};
   localparam logic [13:0] H2 = {2'b11, 3'd2, 9'h05C};

   initial begin
      logic [47:0] prev;
      dir[0] = {H1, 6'b000011, 6'b001110, 6'b000111, 6'b001000, 6'b000101, 4'b1010};
      dir[1] = {H2, 3'b100, 31'h4000_0001};
      dir[2] = {H1, 3'b010, 8'hF0, 3'b011, 16'h7FFF, 4'b0000};
      dir[3] = {H2, 3'b101, 16'h8000, 3'b110, 12'hABC};
      dir[4] = {H1, 4'b1111, 3'd2, 3'd6, 4'b1110, 3'd4, 6'b000001, 6'b001010, 5'b11111};
      dir[5] = {H2, 4'b1110, 3'd3, 4'b1110, 3'd1, 4'b1110, 3'd7, 4'b1110, 3'd0, 6'b000010};
      dir[6] = 48'h0;
      dir[7] = {48{1'b1}};
      dir[8] = {H1, 3'b011, 16'h8001, 3'b010, 8'h7F, 4'b0000};

      rst_n   = 1'b0;
      op_word = {48{1'b1}};
      repeat (3) begin
         @(negedge clk);
         check({spec_count, spec_valid, cond_mode, cond_stack, opcode} == '0 &&
               spec_value == '0 && spec_kind == '0 && spec_len == '0,
               "R10", "reset outputs", longint'(spec_count), 0);
      end
      rst_n   = 1'b1;
      op_word = dir[0];
      prev    = dir[0];
      for (int i = 1; i < 9 + 400; i++) begin
         @(negedge clk);
         compare(prev);
         if (i < 9) op_word = dir[i];
         else       op_word = {$urandom(), $urandom()} >> 16;
         prev = op_word;
      end
      @(negedge clk);
      compare(prev);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #40000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule